// File: doc/BRIEF.md
# Panel Self-Refresh State Sequencer

This block tracks where a display source stands in its panel self-refresh cycle. Software controls it with three levels and one pulse: an enable, a mode-valid qualifier, an active-entry level and a single-frame-update request. The hardware-driven moves are timed by a frame-start pulse and a link-done strobe. The AUX traffic, link training and framebuffer data all stay outside the block. They appear here only as those two strobes.

The sequencer has six states, with these codes:

- 0: off
- 1: idle (enabled but not self-refreshing)
- 2: entering (sending a static frame on the way to active)
- 3: active, with no remote-buffer update
- 4: active, with one frame being updated
- 5: leaving

Software makes the moves 0→1, 1→2 and 3→5, and it returns the block to 0. The hardware makes the moves 2→3, 3→4, 4→3 and 5→1 by itself. A single-frame-update request is held as a pending flag. That flag clears itself when the one-frame update finishes and the block is back in state 3. The outputs are the state code, an active flag and an in-transition flag. Software waits on the in-transition flag before it disables the block.

Top module: `selfrefresh_sequencer`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the state code is 0 (off) and the active, in-transition and pending outputs are all low.
- R2: In state 0, enable and mode-valid both high at a rising edge move the block to state 1 (idle) after that edge. Enable high with mode-valid low leaves it in state 0.
- R3: In state 1, with enable high, an active-entry level of 1 moves the block to state 2. In state 2 the next frame-start pulse moves it to state 3.
- R4: An update request pulse in state 1, 2 or 3 sets the pending output. In state 3, with pending set and active-entry high, a frame-start moves the block to state 4. In state 4 the next frame-start moves it back to state 3 and clears pending in the same cycle.
- R5: In state 3, with enable high, active-entry at 0 moves the block straight to state 5 and never passes through state 4, even when pending is set. In state 5 a link-done strobe moves it back to state 1.
- R6: The active output is high exactly when the state code is 3 or 4.
- R7: The in-transition output is high in states 2, 4 and 5, and also in state 3 while pending is set. It is low in all other cases.
- R8: Enable low in state 1 or state 3 returns the block to state 0 and clears pending. In state 3 this takes priority over the exit and the frame update.
- R9: Any request that is not legal in the current state leaves the state code unchanged. This covers:
  - enable low in states 2, 4 and 5;
  - frame-start in states 0, 1 and 5;
  - link-done outside state 5;
  - an update request in states 0, 4 and 5, which also leaves pending unchanged.
- R10: Each move shows on the state code exactly one clock after the edge at which its condition was sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlEnable | input | 1 | Self-refresh enable level |
| ctlModeOk | input | 1 | Mode and transmitter selects valid, needed to leave state 0 |
| ctlEntry | input | 1 | Active-entry level |
| updReq | input | 1 | Single-frame-update request pulse |
| frameStart | input | 1 | Frame-start pulse |
| linkDone | input | 1 | Link re-established strobe that ends the exit |
| stateCode | output | 3 | Current state code, 0 to 5 |
| activeFlag | output | 1 | High in states 3 and 4 |
| inTransition | output | 1 | High while a hardware-driven move is under way or pending |
| updPending | output | 1 | Single-frame update requested and not yet completed |

## Verification
Every state lives in one register that drives the state code directly, so a wrong move shows on the outputs one clock after the edge that caused it. The active and in-transition flags then disagree with the code in that same cycle. A pending flag that never self-clears has its own signature: in-transition stays high in state 3 and the block re-enters state 4 on the next frame-start. Both appear within two frame pulses. The stimulus combines directed walks through every legal move with illegal requests in each state. A long random phase follows, and a reference model checks its outputs cycle by cycle.

// File: rtl/sr_pkg.sv
package sr_pkg;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    ST_OFF    = 3'd0,
    ST_IDLE   = 3'd1,
    ST_ENTER  = 3'd2,
    ST_HOLD   = 3'd3,
    ST_UPDATE = 3'd4,
    ST_LEAVE  = 3'd5
  } srState_e;

  // Strobes from control to datapath; at most one "to*" strobe per cycle.
  typedef struct packed {
    logic toOff;
    logic toIdle;
    logic toEnter;
    logic toHold;
    logic toUpdate;
    logic toLeave;
    logic armUpd;
    logic dropUpd;
  } srStrobe_t;
endpackage

// File: rtl/sr_ctrl.sv
module sr_ctrl
  import sr_pkg::*;
(
  input  srState_e  state,
  input  logic      updPending,
  input  logic      ctlEnable,
  input  logic      ctlModeOk,
  input  logic      ctlEntry,
  input  logic      updReq,
  input  logic      frameStart,
  input  logic      linkDone,
  output srStrobe_t stb
);
  always_comb begin
    stb = '0;
    unique case (state)
      ST_OFF: begin
        if (ctlEnable && ctlModeOk) stb.toIdle = 1'b1;
      end
      ST_IDLE: begin
        if (!ctlEnable) begin
          stb.toOff   = 1'b1;
          stb.dropUpd = 1'b1;
        end else begin
          if (ctlEntry) stb.toEnter = 1'b1;
          if (updReq)   stb.armUpd  = 1'b1;
        end
      end
      ST_ENTER: begin
        if (frameStart) stb.toHold = 1'b1;
        if (updReq)     stb.armUpd = 1'b1;
      end
      ST_HOLD: begin
        if (!ctlEnable) begin
          stb.toOff   = 1'b1;
          stb.dropUpd = 1'b1;
        end else begin
          if (!ctlEntry)                     stb.toLeave  = 1'b1;
          else if (updPending && frameStart) stb.toUpdate = 1'b1;
          if (updReq) stb.armUpd = 1'b1;
        end
      end
      ST_UPDATE: begin
        if (frameStart) begin
          stb.toHold  = 1'b1;
          stb.dropUpd = 1'b1;
        end
      end
      ST_LEAVE: begin
        if (linkDone) stb.toIdle = 1'b1;
      end
      default: begin
        stb.toOff   = 1'b1;
        stb.dropUpd = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/sr_datapath.sv
module sr_datapath
  import sr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  srStrobe_t        stb,
  output srState_e         state,
  output logic             updPending,
  output logic [CODE_W-1:0] stateCode,
  output logic             activeFlag,
  output logic             inTransition
);
  srState_e stateQ, stateD;
  logic     pendQ, pendD;

  always_comb begin
    stateD = stateQ;
    if      (stb.toOff)    stateD = ST_OFF;
    else if (stb.toIdle)   stateD = ST_IDLE;
    else if (stb.toEnter)  stateD = ST_ENTER;
    else if (stb.toHold)   stateD = ST_HOLD;
    else if (stb.toUpdate) stateD = ST_UPDATE;
    else if (stb.toLeave)  stateD = ST_LEAVE;
  end

  always_comb begin
    pendD = pendQ;
    if      (stb.dropUpd) pendD = 1'b0;
    else if (stb.armUpd)  pendD = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_OFF;
      pendQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      pendQ  <= pendD;
    end
  end

  assign state        = stateQ;
  assign updPending   = pendQ;
  assign stateCode    = stateQ;
  assign activeFlag   = (stateQ == ST_HOLD) || (stateQ == ST_UPDATE);
  assign inTransition = (stateQ == ST_ENTER) || (stateQ == ST_UPDATE) ||
                        (stateQ == ST_LEAVE) || ((stateQ == ST_HOLD) && pendQ);
endmodule

// File: rtl/selfrefresh_sequencer.sv
module selfrefresh_sequencer
  import sr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlEnable,
  input  logic              ctlModeOk,
  input  logic              ctlEntry,
  input  logic              updReq,
  input  logic              frameStart,
  input  logic              linkDone,
  output logic [CODE_W-1:0] stateCode,
  output logic              activeFlag,
  output logic              inTransition,
  output logic              updPending
);
  srState_e  state;
  srStrobe_t stb;

  sr_ctrl u_ctrl (
    .state      (state),
    .updPending (updPending),
    .ctlEnable  (ctlEnable),
    .ctlModeOk  (ctlModeOk),
    .ctlEntry   (ctlEntry),
    .updReq     (updReq),
    .frameStart (frameStart),
    .linkDone   (linkDone),
    .stb        (stb)
  );

  sr_datapath u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .state        (state),
    .updPending   (updPending),
    .stateCode    (stateCode),
    .activeFlag   (activeFlag),
    .inTransition (inTransition)
  );
endmodule

// File: rtl/sr_checker.sv
module sr_checker
  import sr_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              ctlEnable,
  input logic              ctlModeOk,
  input logic              ctlEntry,
  input logic              updReq,
  input logic              frameStart,
  input logic              linkDone,
  input logic [CODE_W-1:0] stateCode,
  input logic              activeFlag,
  input logic              inTransition,
  input logic              updPending
);
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    stateCode <= 3'd5); // R9
  AST_OFF_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'd0 && ctlEnable && ctlModeOk) |=> stateCode == 3'd1); // R2
  AST_ENTER_TO_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'd2 && frameStart) |=> stateCode == 3'd3); // R3
  AST_UPDATE_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'd4 && frameStart) |=> (stateCode == 3'd3 && !updPending)); // R4
  AST_EXIT_DIRECT: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'd3 && ctlEnable && !ctlEntry) |=> stateCode == 3'd5); // R5
  AST_LEAVE_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'd5 && linkDone) |=> stateCode == 3'd1); // R5
  AST_ACTIVE_CODES: assert property (@(posedge clk) disable iff (!rstN)
    activeFlag |-> (stateCode == 3'd3 || stateCode == 3'd4)); // R6
  AST_TRANS_LEAVE: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'd5) |-> inTransition); // R7
  AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    ((stateCode == 3'd1 || stateCode == 3'd3) && !ctlEnable) |=> (stateCode == 3'd0 && !updPending)); // R8
  AST_LEAVE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'd5 && !linkDone) |=> $stable(stateCode)); // R9
endmodule

bind selfrefresh_sequencer sr_checker u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .ctlEnable    (ctlEnable),
  .ctlModeOk    (ctlModeOk),
  .ctlEntry     (ctlEntry),
  .updReq       (updReq),
  .frameStart   (frameStart),
  .linkDone     (linkDone),
  .stateCode    (stateCode),
  .activeFlag   (activeFlag),
  .inTransition (inTransition),
  .updPending   (updPending)
);

// File: tb/tb_selfrefresh_sequencer.sv
module tb_selfrefresh_sequencer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctlEnable = 0, ctlModeOk = 0, ctlEntry = 0, updReq = 0, frameStart = 0, linkDone = 0;
  logic [2:0] stateCode;
  logic activeFlag, inTransition, updPending;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk; // 50 MHz

  selfrefresh_sequencer dut (
    .clk(clk), .rstN(rstN), .ctlEnable(ctlEnable), .ctlModeOk(ctlModeOk),
    .ctlEntry(ctlEntry), .updReq(updReq), .frameStart(frameStart), .linkDone(linkDone),
    .stateCode(stateCode), .activeFlag(activeFlag), .inTransition(inTransition),
    .updPending(updPending)
  );

  typedef struct {
    logic [2:0] st;
    logic act;
    logic trn;
    logic pnd;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  logic [2:0] mSt = 3'd0;
  logic mPend = 1'b0;

  task automatic compare(input expItem_t e);
    checks++;
    if (stateCode !== e.st || activeFlag !== e.act || inTransition !== e.trn || updPending !== e.pnd) begin
      errors++;
      $display("FAIL %s: got state=%0d act=%0b trn=%0b pend=%0b, expected state=%0d act=%0b trn=%0b pend=%0b",
               e.tag, stateCode, activeFlag, inTransition, updPending, e.st, e.act, e.trn, e.pnd);
    end
  endtask

  // Reference model taken from the requirements.
  task automatic model(input logic e, m, n, u, f, l);
    logic [2:0] ns = mSt;
    logic np = mPend;
    case (mSt)
      3'd0: if (e && m) ns = 3'd1;
      3'd1: if (!e) begin ns = 3'd0; np = 1'b0; end
            else begin if (n) ns = 3'd2; if (u) np = 1'b1; end
      3'd2: begin if (f) ns = 3'd3; if (u) np = 1'b1; end
      3'd3: if (!e) begin ns = 3'd0; np = 1'b0; end
            else begin
              if (!n) ns = 3'd5; else if (mPend && f) ns = 3'd4;
              if (u) np = 1'b1;
            end
      3'd4: if (f) begin ns = 3'd3; np = 1'b0; end
      3'd5: if (l) ns = 3'd1;
      default: ns = 3'd0;
    endcase
    mSt = ns;
    mPend = np;
  endtask

  task automatic step(input logic e, m, n, u, f, l, input string tag);
    expItem_t it;
    @(negedge clk);
    ctlEnable = e; ctlModeOk = m; ctlEntry = n; updReq = u; frameStart = f; linkDone = l;
    model(e, m, n, u, f, l);
    it.st = mSt;
    it.act = (mSt == 3'd3) || (mSt == 3'd4);
    it.trn = (mSt == 3'd2) || (mSt == 3'd4) || (mSt == 3'd5) || (mSt == 3'd3 && mPend);
    it.pnd = mPend;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  // Monitor: samples 5 ns after each rising edge.
  always @(posedge clk) begin
    #5;
    if (expQ.size() > 0) compare(expQ.pop_front());
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    expItem_t r;
    repeat (3) @(negedge clk);
    r.st = 3'd0; r.act = 0; r.trn = 0; r.pnd = 0; r.tag = "R1 reset";
    compare(r);
    @(negedge clk) rstN = 1'b1;

    step(1,0,0,0,0,0, "R1 R2 enable without mode stays off");
    step(0,0,0,0,1,1, "R9 strobes ignored in off");
    step(0,0,0,1,0,0, "R9 update request ignored in off");
    step(1,1,0,0,0,0, "R2 R10 off to idle");
    step(1,0,0,1,0,0, "R4 request armed in idle");
    step(1,0,0,0,1,1, "R9 frame and link ignored in idle");
    step(1,0,1,0,0,0, "R3 idle to entering");
    step(0,0,1,0,0,0, "R9 disable ignored while entering");
    step(1,0,1,0,1,0, "R3 entering to active, R7 pending");
    step(1,0,1,0,1,0, "R4 active to update");
    step(0,0,0,1,0,0, "R9 disable, exit and request ignored in update");
    step(1,0,1,0,1,0, "R4 update done, pending self-clears");
    step(1,0,1,0,1,0, "R6 frame without pending stays active");
    step(1,0,1,1,0,1, "R4 request armed in active, R9 link ignored");
    step(1,0,0,0,1,0, "R5 exit skips update state");
    step(0,0,0,1,1,0, "R9 disable, frame and request ignored in leaving");
    step(1,0,0,0,0,1, "R5 leaving to idle");
    step(0,0,0,0,0,0, "R8 idle disable clears pending");
    step(1,1,1,0,0,0, "R2 re-enable");
    step(1,0,1,1,0,0, "R3 entering again");
    step(1,0,1,0,1,0, "R3 active again");
    step(0,0,0,0,1,0, "R8 disable wins over exit and update in active");
    step(0,0,0,0,0,0, "R1 settle off");

    for (int i = 0; i < 600; i++) begin
      step(($urandom % 10) != 0, ($urandom % 2) == 0, ($urandom % 5) != 0,
           ($urandom % 4) == 0, ($urandom % 3) == 0, ($urandom % 3) == 0,
           "R10 random sequence");
    end

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule